// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a host processor. Requests are captured in a pending register, either on a rising edge or by sampling the line level. A per-line mask then filters them, and a priority resolver weighs the result against the levels the host is still servicing. The output rises only when the best unmasked request outranks every level still in service. This gives properly nested interrupt handling.

The host either acknowledges the interrupt with a one-cycle pulse or polls a status word through the register port. On acknowledge, the controller supplies an 8-bit vector. The upper five bits come from a programmable base and the lower three bits are the level number. The acknowledged level then stays in service until the host issues an end-of-interrupt command, which is either specific or non-specific.

Priority is either fixed, with line 0 highest, or rotating. Under rotation, each level cleared by end-of-interrupt drops to the bottom of the order. If the requesting line has gone away before the acknowledge, the acknowledge still completes and returns a default vector.

Top module: `irq_ctrl8`

Register map, with a 3-bit address:

| Address | Access | Content |
|---|---|---|
| 0 | read/write | Mask register |
| 1 | read/write | Vector base; bits 7:3 are stored |
| 2 | read/write | Control: bit 0 = level mode, bit 1 = rotate |
| 3 | write | End-of-interrupt command |
| 4 | read | Pending register |
| 5 | read | In-service register |
| 6 | read | Poll word |

## Requirements
- R1: After reset, the pending, in-service and mask registers read 0x00, int_out is low, and the block is in fixed priority with edge detection.
- R2: In edge mode (control bit 0 = 0), a pending bit is set only by a low-to-high change on its line. A line held high after its acknowledge does not request again until it has gone low and risen again.
- R3: In level mode (control bit 0 = 1), each pending bit (read at address 4) follows its line one clock later.
- R4: A line whose mask bit (address 0) is 1 never raises int_out, while its pending bit is still recorded. Clearing the mask bit lets the request through.
- R5: int_out is high only when the best unmasked pending level outranks every level in service (in-service register read at address 5). A lower-ranked request waits until the higher in-service levels are cleared.
- R6: When int_ack is high and int_out is high, ack_vector equals {base[7:3], level}. At that clock edge the winning level's in-service bit is set and its pending bit is cleared.
- R7: When int_ack is high and int_out is low, ack_vector equals {base[7:3], 3'd7} and the in-service register is unchanged.
- R8: Under fixed priority (control bit 1 = 0), line 0 ranks highest and line 7 ranks lowest.
- R9: Under rotating priority (control bit 1 = 1), a level cleared by end-of-interrupt becomes the lowest rank, and the level numbered one above it (modulo 8) becomes the highest.
- R10: A write to address 3 with bit 3 = 0 clears the highest-ranked in-service bit. A write with bit 3 = 1 clears the in-service bit named by bits 2:0.
- R11: A read of address 6 returns {1, 4'b0, level} when a request would raise int_out, and 0x00 otherwise. A read that returns a level has the same in-service and pending effect as an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, bit n is level n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (needed for the poll side effect) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| int_out | output | 1 | Interrupt request to the host |
| int_ack | input | 1 | One-cycle acknowledge from the host |
| ack_vector | output | 8 | Vector, valid while int_ack is high |

## Verification
The hardest case to reach from the ports is the spurious acknowledge. The interrupt output must first have risen, and the request must then vanish before the host's acknowledge pulse. An edge-captured request stays latched, so it cannot vanish this way. The bench therefore switches to level mode, raises a line, lets int_out rise, drops the line, and then pulses the acknowledge. It checks for the default level-7 vector and an unchanged in-service register. Rotating priority is checked with a two-line request whose winner under the rotated order differs from its winner under fixed priority.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
    localparam int NLVL  = 8;
    localparam int LVLW  = $clog2(NLVL);
    localparam int DW    = 8;
    localparam int ADDRW = 3;
    localparam int BASEW = DW - LVLW;

    typedef logic [NLVL-1:0] lvec_t;
    typedef logic [LVLW-1:0] lvl_t;

    localparam logic [ADDRW-1:0] A_MASK = 3'd0;
    localparam logic [ADDRW-1:0] A_BASE = 3'd1;
    localparam logic [ADDRW-1:0] A_CTRL = 3'd2;
    localparam logic [ADDRW-1:0] A_EOI  = 3'd3;
    localparam logic [ADDRW-1:0] A_PEND = 3'd4;
    localparam logic [ADDRW-1:0] A_ISR  = 3'd5;
    localparam logic [ADDRW-1:0] A_POLL = 3'd6;

    localparam lvl_t LVL_LAST = lvl_t'(NLVL - 1);

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } pick_t;

    typedef struct packed {
        logic rotate;
        logic level;
    } ctrl_t;

    // Highest-ranked set bit, scanning upward from the level after 'low'
    function automatic pick_t pick_top(lvec_t v, lvl_t low);
        pick_t r;
        lvl_t  idx;
        r = '0;
        for (int k = 0; k < NLVL; k++) begin
            idx = lvl_t'(int'(low) + 1 + k);
            if (!r.valid && v[idx]) begin
                r.valid = 1'b1;
                r.lvl   = idx;
            end
        end
        return r;
    endfunction

    // Rank 0 is the highest priority
    function automatic lvl_t rank_of(lvl_t lvl, lvl_t low);
        return lvl_t'(lvl - low - lvl_t'(1));
    endfunction

    function automatic lvec_t onehot(lvl_t lvl);
        lvec_t r;
        r = '0;
        r[lvl] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/irq8_capture.sv
module irq8_capture
    import irq8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level_mode,
    input  lvec_t irq_in,
    input  lvec_t clr,
    output lvec_t pend
);
    lvec_t prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= irq_in;
            if (level_mode)
                pend <= irq_in;
            else
                pend <= (pend & ~clr) | (irq_in & ~prev);
        end
    end
endmodule

// File: rtl/irq8_resolve.sv
module irq8_resolve
    import irq8_pkg::*;
(
    input  lvec_t pend,
    input  lvec_t mask,
    input  lvec_t isr,
    input  lvl_t  low,
    output pick_t req_top,
    output pick_t isr_top,
    output logic  win
);
    always_comb begin
        req_top = pick_top(pend & ~mask, low);
        isr_top = pick_top(isr, low);
        win     = req_top.valid &&
                  (!isr_top.valid || (rank_of(req_top.lvl, low) < rank_of(isr_top.lvl, low)));
    end
endmodule

// File: rtl/irq8_service.sv
module irq8_service
    import irq8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rotate,
    input  logic  take,
    input  lvl_t  take_lvl,
    input  logic  eoi_cmd,
    input  logic  eoi_spec,
    input  lvl_t  eoi_lvl,
    input  pick_t isr_top,
    output lvec_t isr,
    output lvl_t  low
);
    lvl_t  clr_lvl;
    logic  clr_ok;
    lvec_t clr_mask;
    lvec_t set_mask;

    always_comb begin
        clr_lvl  = eoi_spec ? eoi_lvl : isr_top.lvl;
        clr_ok   = eoi_cmd && (eoi_spec ? isr[eoi_lvl] : isr_top.valid);
        clr_mask = clr_ok ? onehot(clr_lvl) : '0;
        set_mask = take ? onehot(take_lvl) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr <= '0;
            low <= LVL_LAST;
        end else begin
            isr <= (isr & ~clr_mask) | set_mask;
            if (rotate && clr_ok)
                low <= clr_lvl;
        end
    end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
    import irq8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NLVL-1:0]  irq_in,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [ADDRW-1:0] rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             int_out,
    input  logic             int_ack,
    output logic [DW-1:0]    ack_vector
);
    lvec_t            mask_q;
    logic [BASEW-1:0] base_q;
    ctrl_t            ctrl_q;

    lvec_t pend;
    lvec_t isr;
    lvl_t  low_q;
    lvl_t  low_eff;
    pick_t req_top;
    pick_t isr_top;
    logic  win;
    logic  poll_hit;
    logic  take;
    lvec_t take_clr;
    logic  eoi_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MASK:  mask_q <= wr_data;
                A_BASE:  base_q <= wr_data[DW-1:LVLW];
                A_CTRL:  ctrl_q <= ctrl_t'(wr_data[1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        low_eff  = ctrl_q.rotate ? low_q : LVL_LAST;
        poll_hit = rd_en && (rd_addr == A_POLL);
        take     = (int_ack || poll_hit) && win;
        take_clr = take ? onehot(req_top.lvl) : '0;
        eoi_cmd  = wr_en && (wr_addr == A_EOI);
    end

    irq8_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .level_mode (ctrl_q.level),
        .irq_in     (irq_in),
        .clr        (take_clr),
        .pend       (pend)
    );

    irq8_resolve u_res (
        .pend    (pend),
        .mask    (mask_q),
        .isr     (isr),
        .low     (low_eff),
        .req_top (req_top),
        .isr_top (isr_top),
        .win     (win)
    );

    irq8_service u_svc (
        .clk      (clk),
        .rst      (rst),
        .rotate   (ctrl_q.rotate),
        .take     (take),
        .take_lvl (req_top.lvl),
        .eoi_cmd  (eoi_cmd),
        .eoi_spec (wr_data[LVLW]),
        .eoi_lvl  (wr_data[LVLW-1:0]),
        .isr_top  (isr_top),
        .isr      (isr),
        .low      (low_q)
    );

    assign int_out    = win;
    assign ack_vector = {base_q, (win ? req_top.lvl : LVL_LAST)};

    always_comb begin
        case (rd_addr)
            A_MASK:  rd_data = mask_q;
            A_BASE:  rd_data = {base_q, {LVLW{1'b0}}};
            A_CTRL:  rd_data = {{(DW-2){1'b0}}, ctrl_q};
            A_PEND:  rd_data = pend;
            A_ISR:   rd_data = isr;
            A_POLL:  rd_data = win ? {1'b1, {(DW-1-LVLW){1'b0}}, req_top.lvl} : '0;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq8_chk.sv
module irq8_chk
    import irq8_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NLVL-1:0]  irq_in,
    input logic [NLVL-1:0]  pend,
    input logic [NLVL-1:0]  mask,
    input logic [NLVL-1:0]  isr,
    input logic [BASEW-1:0] base,
    input logic             level_mode,
    input logic             eoi_wr,
    input logic             eoi_spec,
    input logic             int_out,
    input logic             int_ack,
    input logic [DW-1:0]    ack_vector
);
    // R4
    int_needs_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((pend & ~mask) != '0));

    // R6
    ack_vector_base_chk: assert property (@(posedge clk) disable iff (rst)
        int_ack |-> (ack_vector[DW-1:LVLW] == base));

    // R6
    ack_sets_service_chk: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_out && !eoi_wr) |=> ($countones(isr) == $past($countones(isr)) + 1));

    // R7
    spurious_no_service_chk: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_out && !eoi_wr) |=> $stable(isr));

    // R2
    edge_only_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !level_mode |=> ((pend & ~$past(pend) & ~$past(irq_in)) == '0));

    // R10
    eoi_clears_one_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !eoi_spec && (isr != '0) && !int_ack) |=>
            ($countones(isr) == $past($countones(isr)) - 1));
endmodule

bind irq_ctrl8 irq8_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .pend       (pend),
    .mask       (mask_q),
    .isr        (isr),
    .base       (base_q),
    .level_mode (ctrl_q.level),
    .eoi_wr     (eoi_cmd),
    .eoi_spec   (wr_data[irq8_pkg::LVLW]),
    .int_out    (int_out),
    .int_ack    (int_ack),
    .ack_vector (ack_vector)
);

// File: tb/tb_irq_ctrl8.sv
`timescale 1ns/1ps
module tb_irq_ctrl8;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       int_out;
    logic       int_ack;
    logic [7:0] ack_vector;

    int total = 0;
    int bad   = 0;

    irq_ctrl8 dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_out(int_out), .int_ack(int_ack), .ack_vector(ack_vector)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk);
        int_ack = 1'b1;
        #1 v = ack_vector;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic eoi_ns();
        wr(3'd3, 8'h00);
    endtask

    task automatic eoi_sp(input logic [2:0] l);
        wr(3'd3, {4'b0, 1'b1, l});
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 int_out", {7'b0, int_out}, 8'h00);
        rd(3'd4, d); chk("R1 pending", d, 8'h00);
        rd(3'd5, d); chk("R1 in-service", d, 8'h00);
        rd(3'd0, d); chk("R1 mask", d, 8'h00);
        rd(3'd2, d); chk("R1 control", d, 8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] d;
        wr(3'd1, 8'h40);
        set_irq(8'h08);
        chk("R2 int_out on rise", {7'b0, int_out}, 8'h01);
        ack(d); chk("R6 vector IR3", d, 8'h43);
        rd(3'd5, d); chk("R6 isr set", d, 8'h08);
        rd(3'd4, d); chk("R6 pending cleared", d, 8'h00);
        eoi_ns();
        rd(3'd5, d); chk("R10 isr after eoi", d, 8'h00);
        rd(3'd4, d); chk("R2 held line no re-request", d, 8'h00);
        chk("R2 held line int_out", {7'b0, int_out}, 8'h00);
        set_irq(8'h00);
        set_irq(8'h08);
        chk("R2 re-rise int_out", {7'b0, int_out}, 8'h01);
        ack(d); chk("R2 re-rise vector", d, 8'h43);
        eoi_ns();
        set_irq(8'h00);
    endtask

    task automatic t_nest();
        logic [7:0] d;
        set_irq(8'h24);
        ack(d); chk("R8 IR2 beats IR5", d, 8'h42);
        chk("R5 lower request blocked", {7'b0, int_out}, 8'h00);
        set_irq(8'h26);
        chk("R5 higher request nests", {7'b0, int_out}, 8'h01);
        ack(d); chk("R5 nested vector", d, 8'h41);
        rd(3'd5, d); chk("R5 two in service", d, 8'h06);
        eoi_ns();
        rd(3'd5, d); chk("R10 nonspecific clears IR1", d, 8'h04);
        chk("R5 IR5 still blocked", {7'b0, int_out}, 8'h00);
        eoi_sp(3'd2);
        rd(3'd5, d); chk("R10 specific clears IR2", d, 8'h00);
        chk("R5 IR5 released", {7'b0, int_out}, 8'h01);
        ack(d); chk("R6 vector IR5", d, 8'h45);
        eoi_sp(3'd5);
        rd(3'd5, d); chk("R10 specific clears IR5", d, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(3'd0, 8'h01);
        set_irq(8'h01);
        chk("R4 masked int_out", {7'b0, int_out}, 8'h00);
        rd(3'd4, d); chk("R4 masked pending kept", d, 8'h01);
        wr(3'd0, 8'h00);
        chk("R4 unmasked int_out", {7'b0, int_out}, 8'h01);
        ack(d); chk("R4 vector IR0", d, 8'h40);
        eoi_ns();
        set_irq(8'h00);
    endtask

    task automatic t_level();
        logic [7:0] d;
        wr(3'd2, 8'h01);
        set_irq(8'h10);
        rd(3'd4, d); chk("R3 level pending high", d, 8'h10);
        set_irq(8'h00);
        rd(3'd4, d); chk("R3 level pending follows low", d, 8'h00);
        set_irq(8'h10);
        chk("R3 level int_out", {7'b0, int_out}, 8'h01);
        set_irq(8'h00);
        chk("R7 int_out after drop", {7'b0, int_out}, 8'h00);
        ack(d); chk("R7 spurious vector", d, 8'h47);
        rd(3'd5, d); chk("R7 isr unchanged", d, 8'h00);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_rotate();
        logic [7:0] d;
        wr(3'd2, 8'h02);
        set_irq(8'h11);
        ack(d); chk("R9 first IR0", d, 8'h40);
        eoi_ns();
        ack(d); chk("R9 then IR4", d, 8'h44);
        eoi_ns();
        set_irq(8'h00);
        set_irq(8'h81);
        ack(d); chk("R9 IR7 outranks IR0 after rotation", d, 8'h47);
        chk("R9 IR0 waits", {7'b0, int_out}, 8'h00);
        eoi_ns();
        ack(d); chk("R9 IR0 last", d, 8'h40);
        eoi_ns();
        set_irq(8'h00);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_poll();
        logic [7:0] d;
        set_irq(8'h40);
        rd(3'd6, d); chk("R11 poll word", d, 8'h86);
        rd(3'd5, d); chk("R11 poll sets isr", d, 8'h40);
        rd(3'd6, d); chk("R11 empty poll", d, 8'h00);
        eoi_ns();
        set_irq(8'h00);
    endtask

    initial begin
        rst = 1'b1; irq_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = '0; int_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edge();
        t_nest();
        t_mask();
        t_level();
        t_rotate();
        t_poll();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule